// File: doc/BRIEF.md
# Dual-Granularity Bit Array Shifter

This block holds two hit occupancy arrays, each a row of single-bit bins indexed by bin number. A write marks one bin of one array as occupied. A read returns both arrays as full-width patterns, each shifted by its own amount. The fine array moves in steps of one bin. The coarse array moves in steps of eight bins. The sum of the two amounts sets the relative displacement between the patterns, and any displacement costs the same single read cycle.

The storage and the shifters form one structure, so no separate copy or scan step is needed between filling and reading. A typical use is to fill both arrays from two detector layers, then issue one read per candidate displacement. A downstream stage ANDs the two patterns bin by bin. A clear request empties both arrays in a single cycle.

Top module: `dual_bit_array_shifter`

## Requirements
- R1: While `rst_ni` is low, every bin of both arrays is zero, `rd_valid_o` is low, both pattern outputs are zero and `busy_o` is high. `busy_o` drops at the first clock edge after reset is released and stays low afterwards.
- R2: A write with `wr_valid_i` high sets bin `wr_bin_i` of the array chosen by `wr_plane_i` at that clock edge. Value 0 selects the fine array and value 1 selects the coarse array. A read issued in the next cycle sees the bin.
- R3: A read returns `fine_pat_o[i] = fine[i + fine_shift_i]`. Bits where `i + fine_shift_i >= 64` read as zero.
- R4: A read returns `coarse_pat_o[i] = coarse[i - 8*coarse_shift_i]`. Bits where `i < 8*coarse_shift_i` read as zero.
- R5: Read results are registered. They appear in the cycle after `rd_valid_i` is high, and `rd_valid_o` is high for that cycle. In a cycle after a cycle with no read, `rd_valid_o` is low and both patterns hold their previous values.
- R6: When a write and a read occur in the same cycle, the read returns the contents as they were before the write.
- R7: Writing a bin that is already set leaves it set and changes no other bin. There is no counting.
- R8: `clr_i` empties both arrays at one clock edge and never raises `busy_o`. A write in the same cycle as a clear is dropped. A read in the same cycle as a clear returns the contents from before the clear.
- R9: A write to one array leaves every bin of the other array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write strobe |
| wr_plane_i | input | 1 | Array select: 0 fine, 1 coarse |
| wr_bin_i | input | 6 | Bin index to set |
| rd_valid_i | input | 1 | Read strobe |
| fine_shift_i | input | 6 | Fine array shift, in single bins |
| coarse_shift_i | input | 3 | Coarse array shift, in groups of eight bins |
| clr_i | input | 1 | Empty both arrays |
| busy_o | output | 1 | High only while the arrays are not yet usable after reset |
| rd_valid_o | output | 1 | Read result valid |
| fine_pat_o | output | 64 | Shifted fine array pattern |
| coarse_pat_o | output | 64 | Shifted coarse array pattern |

## Verification
The bench builds the block with its default 64 bins and a coarse step of eight. At that size the whole shift space fits in a short run: all 64 fine amounts and all 8 coarse amounts are read, and each read is compared with a model computed by shifting a bench-side copy of the arrays. The arrays are filled with two different arithmetic patterns, so every bin position and both zero-fill edges are exercised. The same-cycle write/read, clear/write and clear/read orderings are also covered.

// File: rtl/dbas_pkg.sv
package dbas_pkg;
  typedef enum logic {
    PLANE_FINE   = 1'b0,
    PLANE_COARSE = 1'b1
  } plane_e;
endpackage

// File: rtl/dbas_bin_array.sv
module dbas_bin_array #(
  parameter int NBINS = 64,
  localparam int BIN_W = $clog2(NBINS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             set_i,
  input  logic [BIN_W-1:0] set_bin_i,
  output logic [NBINS-1:0] bins_o
);
  for (genvar g = 0; g < NBINS; g++) begin : g_bin
    localparam logic [BIN_W-1:0] IDX = BIN_W'(g);
    logic hit;
    assign hit = set_i && (set_bin_i == IDX);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      bins_o[g] <= 1'b0;
      else if (clr_i)   bins_o[g] <= 1'b0;
      else if (hit)     bins_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/dbas_fine_shifter.sv
module dbas_fine_shifter #(
  parameter int NBINS = 64,
  localparam int SH_W = $clog2(NBINS)
) (
  input  logic [NBINS-1:0] data_i,
  input  logic [SH_W-1:0]  amt_i,
  output logic [NBINS-1:0] data_o
);
  logic [NBINS-1:0] stage [SH_W+1];
  assign stage[0] = data_i;
  // log-depth barrel, moving higher bins down, zero fill at the top
  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    assign stage[s+1] = amt_i[s] ? (stage[s] >> (1 << s)) : stage[s];
  end
  assign data_o = stage[SH_W];
endmodule

// File: rtl/dbas_coarse_shifter.sv
module dbas_coarse_shifter #(
  parameter int NBINS = 64,
  parameter int STEP  = 8,
  localparam int STEPS = NBINS / STEP,
  localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic [NBINS-1:0] data_i,
  input  logic [CW-1:0]    amt_i,
  output logic [NBINS-1:0] data_o
);
  logic [NBINS-1:0] cand [STEPS];
  // one candidate per step; a single mux level picks it
  for (genvar k = 0; k < STEPS; k++) begin : g_cand
    assign cand[k] = data_i << (k * STEP);
  end
  assign data_o = cand[amt_i];
endmodule

// File: rtl/dual_bit_array_shifter.sv
module dual_bit_array_shifter #(
  parameter int NBINS = 64,
  parameter int STEP  = 8,
  localparam int BIN_W = $clog2(NBINS),
  localparam int STEPS = NBINS / STEP,
  localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic             wr_plane_i,
  input  logic [BIN_W-1:0] wr_bin_i,
  input  logic             rd_valid_i,
  input  logic [BIN_W-1:0] fine_shift_i,
  input  logic [CW-1:0]    coarse_shift_i,
  input  logic             clr_i,
  output logic             busy_o,
  output logic             rd_valid_o,
  output logic [NBINS-1:0] fine_pat_o,
  output logic [NBINS-1:0] coarse_pat_o
);
  import dbas_pkg::*;

  plane_e           plane;
  logic             set_fine, set_coarse;
  logic [NBINS-1:0] fine_bins, coarse_bins;
  logic [NBINS-1:0] fine_sh, coarse_sh;
  logic             busy_q, rd_valid_q;
  logic [NBINS-1:0] fine_pat_q, coarse_pat_q;

  assign plane      = plane_e'(wr_plane_i);
  assign set_fine   = wr_valid_i && !clr_i && (plane == PLANE_FINE);
  assign set_coarse = wr_valid_i && !clr_i && (plane == PLANE_COARSE);

  dbas_bin_array #(.NBINS(NBINS)) u_fine_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .set_i     (set_fine),
    .set_bin_i (wr_bin_i),
    .bins_o    (fine_bins)
  );

  dbas_bin_array #(.NBINS(NBINS)) u_coarse_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .set_i     (set_coarse),
    .set_bin_i (wr_bin_i),
    .bins_o    (coarse_bins)
  );

  dbas_fine_shifter #(.NBINS(NBINS)) u_fine_sh (
    .data_i (fine_bins),
    .amt_i  (fine_shift_i),
    .data_o (fine_sh)
  );

  dbas_coarse_shifter #(.NBINS(NBINS), .STEP(STEP)) u_coarse_sh (
    .data_i (coarse_bins),
    .amt_i  (coarse_shift_i),
    .data_o (coarse_sh)
  );

  // read samples pre-edge contents, so same-cycle writes and clears are not seen
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b1;
      rd_valid_q   <= 1'b0;
      fine_pat_q   <= '0;
      coarse_pat_q <= '0;
    end else begin
      busy_q     <= 1'b0;
      rd_valid_q <= rd_valid_i;
      if (rd_valid_i) begin
        fine_pat_q   <= fine_sh;
        coarse_pat_q <= coarse_sh;
      end
    end
  end

  assign busy_o       = busy_q;
  assign rd_valid_o   = rd_valid_q;
  assign fine_pat_o   = fine_pat_q;
  assign coarse_pat_o = coarse_pat_q;
endmodule

// File: rtl/dbas_checker.sv
module dbas_checker #(
  parameter int NBINS = 64,
  parameter int STEP  = 8,
  localparam int BIN_W = $clog2(NBINS),
  localparam int STEPS = NBINS / STEP,
  localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_valid_i,
  input logic [BIN_W-1:0] fine_shift_i,
  input logic [CW-1:0]    coarse_shift_i,
  input logic             clr_i,
  input logic             busy_o,
  input logic             rd_valid_o,
  input logic [NBINS-1:0] fine_pat_o,
  input logic [NBINS-1:0] coarse_pat_o
);
  logic [NBINS-1:0] fine_mask_d, coarse_mask_d, fine_mask_q, coarse_mask_q;

  always_comb begin
    for (int i = 0; i < NBINS; i++) begin
      fine_mask_d[i]   = (i + int'(fine_shift_i)) >= NBINS;
      coarse_mask_d[i] = i < int'(coarse_shift_i) * STEP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fine_mask_q   <= '0;
      coarse_mask_q <= '0;
    end else begin
      fine_mask_q   <= fine_mask_d;
      coarse_mask_q <= coarse_mask_d;
    end
  end

  // R5
  rd_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> rd_valid_o);

  // R5
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_i |=> (!rd_valid_o && $stable(fine_pat_o) && $stable(coarse_pat_o)));

  // R3
  fine_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> ((fine_pat_o & fine_mask_q) == '0));

  // R4
  coarse_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> ((coarse_pat_o & coarse_mask_q) == '0));

  // R8
  clr_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !busy_o);

  // R8
  clr_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clr_i) && rd_valid_i) |=> (fine_pat_o == '0 && coarse_pat_o == '0));

  // R1
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> !busy_o);
endmodule

bind dual_bit_array_shifter dbas_checker #(.NBINS(NBINS), .STEP(STEP)) u_dbas_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .rd_valid_i     (rd_valid_i),
  .fine_shift_i   (fine_shift_i),
  .coarse_shift_i (coarse_shift_i),
  .clr_i          (clr_i),
  .busy_o         (busy_o),
  .rd_valid_o     (rd_valid_o),
  .fine_pat_o     (fine_pat_o),
  .coarse_pat_o   (coarse_pat_o)
);

// File: tb/dual_bit_array_shifter_test.sv
module dual_bit_array_shifter_test;
  localparam int NBINS = 64;
  localparam int STEP  = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid_i = 1'b0, wr_plane_i = 1'b0;
  logic [5:0]  wr_bin_i = '0;
  logic        rd_valid_i = 1'b0;
  logic [5:0]  fine_shift_i = '0;
  logic [2:0]  coarse_shift_i = '0;
  logic        clr_i = 1'b0;
  logic        busy_o, rd_valid_o;
  logic [63:0] fine_pat_o, coarse_pat_o;

  logic [63:0] m_fine = '0, m_coarse = '0;
  int checks = 0, errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  dual_bit_array_shifter #(.NBINS(NBINS), .STEP(STEP)) uut (.*);

  always #4 clk_i = ~clk_i;  // 125 MHz

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog R5: actual %0d cycles, expected under 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // caller is at a negedge; returns at the following negedge
  task automatic cyc(bit wv, bit wp, int wb, bit rv, int fs, int cs, bit cl);
    wr_valid_i = wv; wr_plane_i = wp; wr_bin_i = 6'(wb);
    rd_valid_i = rv; fine_shift_i = 6'(fs); coarse_shift_i = 3'(cs); clr_i = cl;
    @(negedge clk_i);
    wr_valid_i = 1'b0; rd_valid_i = 1'b0; clr_i = 1'b0;
  endtask

  task automatic wr(bit p, int b);
    cyc(1'b1, p, b, 1'b0, 0, 0, 1'b0);
    if (p) m_coarse[b] = 1'b1; else m_fine[b] = 1'b1;
  endtask

  task automatic rd_chk(string req, int fs, int cs);
    cyc(1'b0, 1'b0, 0, 1'b1, fs, cs, 1'b0);
    chk(req, 64'(rd_valid_o), 64'd1);
    chk(req, fine_pat_o, m_fine >> fs);
    chk(req, coarse_pat_o, m_coarse << (cs * STEP));
  endtask

  initial begin
    logic [63:0] hold_f, hold_c;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 busy", 64'(busy_o), 64'd1);
    chk("R1 rd_valid", 64'(rd_valid_o), 64'd0);
    chk("R1 fine", fine_pat_o, '0);
    chk("R1 coarse", coarse_pat_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 busy drop", 64'(busy_o), 64'd0);
    rd_chk("R1 empty", 0, 0);

    // R2 / R9 single write each plane
    wr(1'b0, 5);
    rd_chk("R2 fine write", 0, 0);
    chk("R9 coarse untouched", coarse_pat_o, '0);
    wr(1'b1, 62);
    rd_chk("R2 coarse write", 0, 0);
    chk("R9 fine untouched", fine_pat_o, 64'd1 << 5);

    // fill two distinct patterns
    for (int b = 0; b < NBINS; b++) begin
      if (b % 3 == 0 || b == 63) wr(1'b0, b);
      if (b % 5 == 1 || b == 0) wr(1'b1, b);
    end

    // R3 / R4 full shift sweep
    for (int cs = 0; cs < NBINS / STEP; cs++)
      for (int fs = 0; fs < NBINS; fs++)
        rd_chk("R3 R4 shift sweep", fs, cs);

    // R7 rewrite of a set bin
    wr(1'b0, 63);
    wr(1'b1, 1);
    rd_chk("R7 rewrite", 0, 0);
    rd_chk("R7 rewrite shifted", 17, 3);

    // R6 write and read together see old contents
    cyc(1'b1, 1'b0, 4, 1'b1, 0, 0, 1'b0);
    chk("R6 pre-write fine", fine_pat_o, m_fine);
    m_fine[4] = 1'b1;
    rd_chk("R6 post-write", 0, 0);
    cyc(1'b1, 1'b1, 7, 1'b1, 0, 1, 1'b0);
    chk("R6 pre-write coarse", coarse_pat_o, m_coarse << 8);
    m_coarse[7] = 1'b1;
    rd_chk("R6 post-write coarse", 0, 1);

    // R5 hold without read
    hold_f = fine_pat_o; hold_c = coarse_pat_o;
    wr(1'b0, 2);
    cyc(1'b0, 1'b0, 0, 1'b0, 9, 5, 1'b0);
    chk("R5 rd_valid low", 64'(rd_valid_o), 64'd0);
    chk("R5 fine hold", fine_pat_o, hold_f);
    chk("R5 coarse hold", coarse_pat_o, hold_c);

    // R8 clear with read: read sees old, then empty; write dropped
    cyc(1'b1, 1'b1, 10, 1'b1, 0, 0, 1'b1);
    chk("R8 read at clear fine", fine_pat_o, m_fine);
    chk("R8 read at clear coarse", coarse_pat_o, m_coarse);
    chk("R8 busy", 64'(busy_o), 64'd0);
    m_fine = '0; m_coarse = '0;
    rd_chk("R8 empty after clear", 0, 0);
    rd_chk("R8 empty shifted", 3, 2);

    // R2 refill after clear, edge bins
    wr(1'b0, 0);
    wr(1'b1, 63);
    rd_chk("R2 edge bins", 0, 0);
    rd_chk("R3 R4 edges out", 1, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule